// File: doc/BRIEF.md
# Raster-Op Solid Rectangle Fill Engine

This block paints a destination rectangle in a pixel frame buffer with one color. An 8-bit raster-op code in a mix word selects the color. It can be the brush foreground color, an opaque black made from one palette RGB entry, or an opaque white made from a second palette entry. The block performs no other raster op. When it sees any other code it makes no writes and reports the operation as unsupported.

A host presents the rectangle geometry and the surface description together with a one-cycle `start`: the origin, width, height, base offset, row pitch in bytes, the pixel type code and a vertical direction bit. The engine checks the parameters, latches them and then walks the rectangle row by row. It issues one pixel-sized byte-enabled write per cycle for as long as the memory side accepts. At the end it updates its destination-Y register and raises `done` for one cycle. In that same cycle `err` or `unsup` report how the operation ended.

Top module: `rop_fill_engine`

## Requirements
- R1: The raster-op code is taken from bits 23:16 of `mix_word`, and all other bits of the word are ignored. Code 0xF0 fills with the 32-bit `brush_color`.
- R2: Code 0x00 fills with the word {8'hFF, `pal_dark`}, where the alpha is forced opaque and the palette RGB sits in the low 24 bits.
- R3: Code 0xFF fills with the word {8'hFF, `pal_light`}.
- R4: With valid parameters, any other code produces no write, and `unsup` is high in the `done` cycle.
- R5: `pix_type` gives the pixel size N: code 2 is 1 byte, codes 3 and 4 are 2 bytes, code 5 is 3 bytes, and code 6 is 4 bytes. `mem_be` enables the low N byte lanes (0x1, 0x3, 0x7 or 0xF). `mem_data` carries the low N bytes of the fill word, and its upper bytes are zero.
- R6: Pixel (c, r) of the rectangle is written at `dst_offset + (dst_y + r) * dst_pitch + (dst_x + c) * N`, modulo 2^ADDR_W. Writes go row by row, with c ascending inside a row and r ascending, whatever the value of `top_down`.
- R7: `mem_req` stays high with `mem_addr`, `mem_data` and `mem_be` stable until a cycle with `mem_ack` high. The next pixel is presented in the following cycle.
- R8: The operation aborts when `dst_pitch` is zero, when `pix_type` is not one of the codes in R5, or when `dst_x` or `dst_y` is above 0x3FFF. An aborted operation makes no write and raises `err` in the `done` cycle. This check takes precedence over R4.
- R9: After a completed fill, including an empty one, `y_out` equals `dst_y + rect_h` when `top_down` is set and `dst_y` otherwise, modulo 2^16. Operations ending in `err` or `unsup` leave `y_out` unchanged. After reset `y_out` is 0.
- R10: `done` is high for exactly one cycle per operation. For aborted, unsupported and empty operations, that cycle is the one after `start` is sampled. For other operations it is the cycle after the last accepted write. A zero width or height produces no write.
- R11: `busy` is high from the cycle after `start` is sampled through the `done` cycle. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| mix_word | input | 32 | Mix word holding the raster-op code in bits 23:16 |
| dst_x | input | COORD_W | Destination left X |
| dst_y | input | COORD_W | Destination top Y |
| rect_w | input | DIM_W | Rectangle width in pixels |
| rect_h | input | DIM_W | Rectangle height in rows |
| dst_offset | input | ADDR_W | Surface base byte address |
| dst_pitch | input | ADDR_W | Row pitch in bytes |
| pix_type | input | 4 | Pixel type code |
| top_down | input | 1 | Vertical direction bit used for the Y update |
| brush_color | input | 32 | Brush foreground color |
| pal_dark | input | 24 | Palette RGB used for black |
| pal_light | input | 24 | Palette RGB used for white |
| mem_req | output | 1 | Pixel write request |
| mem_addr | output | ADDR_W | Pixel byte address |
| mem_data | output | 32 | Pixel data, low lanes |
| mem_be | output | 4 | Byte-lane enables |
| mem_ack | input | 1 | Memory accepts the current write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Parameter error, valid with done |
| unsup | output | 1 | Unsupported raster op, valid with done |
| y_out | output | COORD_W | Destination Y register |

## Verification
The first write request is due in the cycle after the edge that samples `start`. Each accepted write moves to the next pixel one edge later. `done`, `err`, `unsup` and the new `y_out` all appear in the cycle after the final acceptance, or in the cycle right after `start` when nothing is written. The bench keeps an ordered queue of expected writes and samples every output on the falling clock edge, between the edge that launched it and the edge that consumes it. It chooses `mem_ack` in that same slot, so each queue entry is retired exactly when the design's acceptance edge follows. The expected `done` cycle is then defined as the first sample at which the queue is empty.

// File: rtl/rop_fill_pkg.sv
package rop_fill_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_FIN  = 2'd2
  } fill_state_e;

  localparam int          ROP_LSB       = 16;
  localparam logic [7:0]  ROP_PAT_COPY  = 8'hF0;
  localparam logic [7:0]  ROP_ALL_BLACK = 8'h00;
  localparam logic [7:0]  ROP_ALL_WHITE = 8'hFF;
  localparam logic [7:0]  OPAQUE_ALPHA  = 8'hFF;

  // Bytes per pixel for a pixel type code; zero marks an invalid code.
  function automatic logic [2:0] type_to_bytes(input logic [3:0] code);
    case (code)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rop_fill_color.sv
module rop_fill_color
  import rop_fill_pkg::*;
(
  input  logic [31:0] mix_word,
  input  logic [31:0] brush_color,
  input  logic [23:0] pal_dark,
  input  logic [23:0] pal_light,
  input  logic [2:0]  pix_bytes,
  output logic        rop_ok,
  output logic [31:0] fill_word,
  output logic [3:0]  lane_en
);

  logic [7:0]  rop_code;
  logic [31:0] raw_word;
  logic        unused_mix_bits;

  assign rop_code        = mix_word[ROP_LSB +: 8];
  assign unused_mix_bits = ^{mix_word[31:24], mix_word[15:0]};

  always_comb begin
    rop_ok   = 1'b1;
    raw_word = '0;
    case (rop_code)
      ROP_PAT_COPY:  raw_word = brush_color;
      ROP_ALL_BLACK: raw_word = {OPAQUE_ALPHA, pal_dark};
      ROP_ALL_WHITE: raw_word = {OPAQUE_ALPHA, pal_light};
      default:       rop_ok   = 1'b0;
    endcase
  end

  // Keep only the byte lanes that one pixel occupies.
  for (genvar lane = 0; lane < 4; lane++) begin : g_lane
    assign lane_en[lane]           = (3'(lane) < pix_bytes);
    assign fill_word[8*lane +: 8]  = lane_en[lane] ? raw_word[8*lane +: 8] : 8'h00;
  end

endmodule

// File: rtl/rop_fill_guard.sv
module rop_fill_guard #(
  parameter int unsigned COORD_W     = 16,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned COORD_LIMIT = 16383
) (
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [ADDR_W-1:0]  row_pitch,
  input  logic [2:0]         pix_bytes,
  output logic               bad_params
);

  localparam logic [COORD_W-1:0] LIMIT = COORD_W'(COORD_LIMIT);

  logic pitch_zero;
  logic type_bad;
  logic coord_bad;

  assign pitch_zero = (row_pitch == '0);
  assign type_bad   = (pix_bytes == 3'd0);
  assign coord_bad  = (pos_x > LIMIT) || (pos_y > LIMIT);
  assign bad_params = pitch_zero || type_bad || coord_bad;

endmodule

// File: rtl/rop_fill_walker.sv
module rop_fill_walker #(
  parameter int unsigned DIM_W  = 14,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] row_pitch,
  input  logic [2:0]        pix_bytes,
  input  logic [DIM_W-1:0]  cols,
  input  logic [DIM_W-1:0]  rows,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  logic [DIM_W-1:0]  col_q, col_d;
  logic [DIM_W-1:0]  row_q, row_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              end_col;
  logic              end_row;
  logic              walk_en;

  assign end_col = (col_q == cols - DIM_W'(1));
  assign end_row = (row_q == rows - DIM_W'(1));
  assign walk_en = load || step;

  always_comb begin
    col_d  = col_q;
    row_d  = row_q;
    base_d = base_q;
    addr_d = addr_q;
    if (load) begin
      col_d  = '0;
      row_d  = '0;
      base_d = start_addr;
      addr_d = start_addr;
    end else if (step) begin
      if (end_col) begin
        col_d  = '0;
        row_d  = row_q + DIM_W'(1);
        base_d = base_q + row_pitch;
        addr_d = base_q + row_pitch;
      end else begin
        col_d  = col_q + DIM_W'(1);
        addr_d = addr_q + ADDR_W'(pix_bytes);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      base_q <= '0;
      addr_q <= '0;
    end else if (walk_en) begin
      col_q  <= col_d;
      row_q  <= row_d;
      base_q <= base_d;
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;
  assign last = end_col && end_row;

endmodule

// File: rtl/rop_fill_engine.sv
module rop_fill_engine
  import rop_fill_pkg::*;
#(
  parameter int unsigned COORD_W     = 16,
  parameter int unsigned DIM_W       = 14,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned COORD_LIMIT = 16383
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        mix_word,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [DIM_W-1:0]   rect_w,
  input  logic [DIM_W-1:0]   rect_h,
  input  logic [ADDR_W-1:0]  dst_offset,
  input  logic [ADDR_W-1:0]  dst_pitch,
  input  logic [3:0]         pix_type,
  input  logic               top_down,
  input  logic [31:0]        brush_color,
  input  logic [23:0]        pal_dark,
  input  logic [23:0]        pal_light,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [31:0]        mem_data,
  output logic [3:0]         mem_be,
  input  logic               mem_ack,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               unsup,
  output logic [COORD_W-1:0] y_out
);

  fill_state_e        state_q, state_d;

  logic [2:0]         pix_bytes;
  logic               bad_params;
  logic               rop_ok;
  logic [31:0]        fill_word;
  logic [3:0]         lane_en;
  logic               empty_rect;
  logic               accept;
  logic               go_run;
  logic               fill_ok;
  logic [ADDR_W-1:0]  start_addr;
  logic [COORD_W-1:0] y_target;

  logic [31:0]        word_q;
  logic [3:0]         lanes_q;
  logic [DIM_W-1:0]   cols_q, rows_q;
  logic [ADDR_W-1:0]  pitch_q;
  logic [2:0]         bytes_q;
  logic [COORD_W-1:0] ytgt_q;
  logic               err_q, err_d;
  logic               unsup_q, unsup_d;
  logic [COORD_W-1:0] y_q, y_d;
  logic               y_en;

  logic               step;
  logic               walk_last;
  logic [ADDR_W-1:0]  walk_addr;

  assign pix_bytes = type_to_bytes(pix_type);

  rop_fill_color u_color (
    .mix_word    (mix_word),
    .brush_color (brush_color),
    .pal_dark    (pal_dark),
    .pal_light   (pal_light),
    .pix_bytes   (pix_bytes),
    .rop_ok      (rop_ok),
    .fill_word   (fill_word),
    .lane_en     (lane_en)
  );

  rop_fill_guard #(
    .COORD_W     (COORD_W),
    .ADDR_W      (ADDR_W),
    .COORD_LIMIT (COORD_LIMIT)
  ) u_guard (
    .pos_x      (dst_x),
    .pos_y      (dst_y),
    .row_pitch  (dst_pitch),
    .pix_bytes  (pix_bytes),
    .bad_params (bad_params)
  );

  // Start-of-operation decisions, all from the live inputs.
  assign accept     = start && (state_q == FS_IDLE);
  assign empty_rect = (rect_w == '0) || (rect_h == '0);
  assign fill_ok    = !bad_params && rop_ok;
  assign go_run     = accept && fill_ok && !empty_rect;
  assign start_addr = dst_offset
                    + ADDR_W'(dst_y) * dst_pitch
                    + ADDR_W'(dst_x) * ADDR_W'(pix_bytes);
  assign y_target   = dst_y + (top_down ? COORD_W'(rect_h) : '0);

  assign step = (state_q == FS_RUN) && mem_ack;

  rop_fill_walker #(
    .DIM_W  (DIM_W),
    .ADDR_W (ADDR_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go_run),
    .step       (step),
    .start_addr (start_addr),
    .row_pitch  (pitch_q),
    .pix_bytes  (bytes_q),
    .cols       (cols_q),
    .rows       (rows_q),
    .addr       (walk_addr),
    .last       (walk_last)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unsup_d = unsup_q;
    y_en    = 1'b0;
    y_d     = y_q;
    case (state_q)
      FS_IDLE: begin
        if (accept) begin
          err_d   = bad_params;
          unsup_d = !bad_params && !rop_ok;
          state_d = go_run ? FS_RUN : FS_FIN;
          if (fill_ok && empty_rect) begin
            y_en = 1'b1;
            y_d  = y_target;
          end
        end
      end
      FS_RUN: begin
        if (mem_ack && walk_last) begin
          state_d = FS_FIN;
          y_en    = 1'b1;
          y_d     = ytgt_q;
        end
      end
      FS_FIN:  state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      err_q   <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      unsup_q <= unsup_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      lanes_q <= '0;
      cols_q  <= '0;
      rows_q  <= '0;
      pitch_q <= '0;
      bytes_q <= '0;
      ytgt_q  <= '0;
    end else if (accept) begin
      word_q  <= fill_word;
      lanes_q <= lane_en;
      cols_q  <= rect_w;
      rows_q  <= rect_h;
      pitch_q <= dst_pitch;
      bytes_q <= pix_bytes;
      ytgt_q  <= y_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (y_en) begin
      y_q <= y_d;
    end
  end

  assign mem_req  = (state_q == FS_RUN);
  assign mem_addr = walk_addr;
  assign mem_data = word_q;
  assign mem_be   = lanes_q;
  assign busy     = (state_q != FS_IDLE);
  assign done     = (state_q == FS_FIN);
  assign err      = done && err_q;
  assign unsup    = done && unsup_q;
  assign y_out    = y_q;

endmodule

// File: rtl/rop_fill_props.sv
module rop_fill_props #(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned ADDR_W  = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [ADDR_W-1:0]  dst_pitch,
  input logic               mem_req,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [31:0]        mem_data,
  input logic [3:0]         mem_be,
  input logic               mem_ack,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic               unsup,
  input logic [COORD_W-1:0] y_out
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_back_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_unsup_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> done);

  assert_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_err_over_unsup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && unsup));

  assert_zero_pitch_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && dst_pitch == '0) |=> (done && err && !mem_req));

  assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                               && $stable(mem_data) && $stable(mem_be)));

  assert_lane_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  assert_y_moves_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_out) |-> done);

endmodule

bind rop_fill_engine rop_fill_props #(
  .COORD_W (COORD_W),
  .ADDR_W  (ADDR_W)
) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dst_pitch (dst_pitch),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_be    (mem_be),
  .mem_ack   (mem_ack),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .unsup     (unsup),
  .y_out     (y_out)
);

// File: tb/rop_fill_engine_test.sv
module rop_fill_engine_test;

  localparam int COORD_W = 16;
  localparam int DIM_W   = 14;
  localparam int ADDR_W  = 20;
  localparam longint AMASK = (64'd1 << ADDR_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [31:0]        mix_word = '0;
  logic [COORD_W-1:0] dst_x = '0;
  logic [COORD_W-1:0] dst_y = '0;
  logic [DIM_W-1:0]   rect_w = '0;
  logic [DIM_W-1:0]   rect_h = '0;
  logic [ADDR_W-1:0]  dst_offset = '0;
  logic [ADDR_W-1:0]  dst_pitch = '0;
  logic [3:0]         pix_type = '0;
  logic               top_down = 1'b0;
  logic [31:0]        brush_color = 32'h1234_5678;
  logic [23:0]        pal_dark = 24'h0A0B0C;
  logic [23:0]        pal_light = 24'hF1F2F3;
  logic               mem_req;
  logic [ADDR_W-1:0]  mem_addr;
  logic [31:0]        mem_data;
  logic [3:0]         mem_be;
  logic               mem_ack;
  logic               busy, done, err, unsup;
  logic [COORD_W-1:0] y_out;

  rop_fill_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mix_word(mix_word),
    .dst_x(dst_x), .dst_y(dst_y), .rect_w(rect_w), .rect_h(rect_h),
    .dst_offset(dst_offset), .dst_pitch(dst_pitch), .pix_type(pix_type),
    .top_down(top_down), .brush_color(brush_color), .pal_dark(pal_dark),
    .pal_light(pal_light), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .mem_ack(mem_ack), .busy(busy),
    .done(done), .err(err), .unsup(unsup), .y_out(y_out)
  );

  always #5 clk = ~clk;

  int     n_checks = 0;
  int     n_fail   = 0;
  int     cycles   = 0;
  bit     mon_on   = 0;
  bit     model_active = 0;
  bit     ack_always = 0;
  bit     exp_err, exp_unsup;
  longint exp_y = 0;
  string  color_tag = "R1";
  longint q_addr[$];
  longint q_data[$];
  longint q_be[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference model: compares every output on each falling edge.
  always @(negedge clk) begin
    if (!mon_on) begin
      mem_ack = 1'b0;
    end else begin
      mem_ack = ack_always ? 1'b1 : ($urandom_range(3) != 0);
      if (model_active) begin
        chk(busy == 1'b1, "R11", "busy during operation", busy, 1);
        if (q_addr.size() > 0) begin
          chk(mem_req == 1'b1, "R7", "write request pending", mem_req, 1);
          chk(done == 1'b0, "R10", "done before last write", done, 0);
          if (mem_req) begin
            chk(mem_addr == q_addr[0], "R6", "pixel address", mem_addr, q_addr[0]);
            chk(mem_data == q_data[0], color_tag, "fill data", mem_data, q_data[0]);
            chk(mem_be == q_be[0], "R5", "byte enables", mem_be, q_be[0]);
            if (mem_ack) begin
              void'(q_addr.pop_front());
              void'(q_data.pop_front());
              void'(q_be.pop_front());
            end
          end
        end else begin
          chk(mem_req == 1'b0, "R7", "no extra write", mem_req, 0);
          chk(done == 1'b1, "R10", "done pulse", done, 1);
          chk(err == exp_err, "R8", "error flag", err, exp_err);
          chk(unsup == exp_unsup, "R4", "unsupported flag", unsup, exp_unsup);
          chk(y_out == exp_y[15:0], "R9", "destination Y", y_out, exp_y);
          model_active = 0;
        end
      end else begin
        chk(!busy && !mem_req && !done, "R11", "idle outputs",
            {busy, mem_req, done}, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run_op(input logic [31:0] mix, input int x, input int y,
                        input int w, input int h, input int off, input int pitch,
                        input int dt, input bit td, input bit poke);
    int nb;
    bit bad, supp;
    longint word, mask;
    logic [7:0] rop;
    nb = (dt == 2) ? 1 : (dt == 3 || dt == 4) ? 2 : (dt == 5) ? 3 : (dt == 6) ? 4 : 0;
    rop = mix[23:16];
    bad = (pitch == 0) || (nb == 0) || (x > 16383) || (y > 16383);
    supp = 1;
    word = 0;
    if (rop == 8'hF0) begin word = brush_color; color_tag = "R1"; end
    else if (rop == 8'h00) begin word = {8'hFF, pal_dark}; color_tag = "R2"; end
    else if (rop == 8'hFF) begin word = {8'hFF, pal_light}; color_tag = "R3"; end
    else supp = 0;
    mask = (nb == 0) ? 0 : ((64'd1 << (8 * nb)) - 1);
    exp_err = bad;
    exp_unsup = !bad && !supp;
    if (!bad && supp) begin
      for (int r = 0; r < h; r++) begin
        for (int c = 0; c < w; c++) begin
          q_addr.push_back((longint'(off) + longint'(y + r) * pitch
                            + longint'(x + c) * nb) & AMASK);
          q_data.push_back(word & mask);
          q_be.push_back((64'd1 << nb) - 1);
        end
      end
      exp_y = (longint'(y) + (td ? h : 0)) & 64'hFFFF;
    end
    @(negedge clk);
    mix_word = mix; dst_x = COORD_W'(x); dst_y = COORD_W'(y);
    rect_w = DIM_W'(w); rect_h = DIM_W'(h); dst_offset = ADDR_W'(off);
    dst_pitch = ADDR_W'(pitch); pix_type = 4'(dt); top_down = td;
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    model_active = 1;
    if (poke) begin
      // R11: a start while busy with bad parameters must change nothing.
      repeat (2) @(negedge clk);
      dst_pitch = '0;
      mix_word = 32'h0033_0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (!model_active);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    chk(!busy && !done && !mem_req && !err && !unsup, "R11", "reset outputs",
        {busy, done, mem_req, err, unsup}, 0);
    chk(y_out == 0, "R9", "reset Y", y_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R1 brush fill, 32 bpp, top-down, other mix bits set
    run_op(32'hABF0_1234, 5, 7, 3, 2, 'h1000, 256, 6, 1, 0);
    // R2 black fill, 16 bpp, bottom-up keeps Y
    run_op(32'h0000_0000, 10, 20, 4, 3, 'h400, 128, 3, 0, 0);
    // R3 white fill, 8 bpp, code 2
    run_op(32'h00FF_0000, 1, 2, 5, 2, 'h20, 64, 2, 1, 0);
    // R5 24 bpp white, and 16 bpp via code 4 brush
    run_op(32'h00FF_0000, 3, 0, 2, 2, 0, 100, 5, 1, 0);
    run_op(32'h00F0_0000, 0, 4, 3, 1, 'h7F0, 40, 4, 0, 0);
    // R6 address wraps modulo the address width
    run_op(32'h00F0_0000, 2, 1, 2, 2, 'hFFFF8, 8, 6, 1, 0);
    // R7 with the memory always ready
    ack_always = 1;
    run_op(32'h0000_0000, 0, 0, 4, 2, 'h300, 32, 6, 1, 0);
    ack_always = 0;
    // R4 unsupported op: no writes, Y unchanged
    run_op(32'h00CC_0000, 4, 4, 3, 3, 0, 64, 6, 1, 0);
    // R8 aborts: pitch, type, X and Y limits, precedence over R4
    run_op(32'h00F0_0000, 0, 0, 2, 2, 0, 0, 6, 1, 0);
    run_op(32'h00F0_0000, 0, 0, 2, 2, 0, 64, 7, 1, 0);
    run_op(32'h00F0_0000, 'h4000, 0, 1, 1, 0, 64, 6, 1, 0);
    run_op(32'h0033_0000, 0, 'h4000, 1, 1, 0, 64, 6, 1, 0);
    // R8 boundary: coordinate exactly at the limit is accepted
    run_op(32'h00F0_0000, 'h3FFF, 'h3FFF, 1, 1, 0, 16, 2, 1, 0);
    // R10 empty rectangles complete with no writes and update Y
    run_op(32'h00F0_0000, 1, 30, 0, 5, 0, 64, 6, 1, 0);
    run_op(32'h00FF_0000, 1, 40, 5, 0, 0, 64, 6, 0, 0);
    // R11 start while busy ignored
    run_op(32'h00F0_0000, 6, 6, 4, 3, 'h200, 64, 6, 1, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule